// File: doc/BRIEF.md
# Latched Cartridge Real-Time Clock Registers

This block keeps time of day for a cartridge-style memory controller. It counts seconds, minutes and hours and keeps a 9-bit day counter. A single-cycle tick input, one pulse per second, advances the count. The processor never reads the running count directly. It reads a frozen snapshot that is refreshed only when a two-step latch sequence is written.

All processor access goes through one write port, which carries a region code and a data byte. A select write either chooses an external RAM bank, which turns clock access off, or chooses one of five clock registers, which turns clock access on. While clock access is on, the read output presents the chosen snapshot register. A data write then loads the matching field of the running counter. The day-high register holds bit 8 of the day count, a halt bit that freezes counting, and a sticky flag that is set when the day count wraps.

Top module: `rtc_latch_regs`

## Requirements
- R1: A write with `wr_region`=2 and data 0..3 sets `ram_bank` to the data value and turns clock access off. While clock access is off, `rd_data` reads 0xFF.
- R2: A write with `wr_region`=2 and data 0x08..0x0C selects clock register (data-8) and turns clock access on. Data 0x04..0x07 and 0x0D..0xFF leave the bank, the selection and the access state unchanged.
- R3: Register index 0 is seconds (0..59), 1 is minutes (0..59), 2 is hours (0..23), 3 is the low 8 bits of the day count and 4 is day-high. Each cycle with `tick` high advances seconds by one. Seconds carry into minutes at 60, minutes into hours at 60, and hours into days at 24.
- R4: Day-high bit 0 is bit 8 of the day count, so the day count runs 0..511. Day-high bits 5:1 read 0, and the unused upper bits of seconds, minutes and hours read 0.
- R5: Day-high bit 7 is set when the day count wraps from 511 to 0. It stays set through later ticks until a data write to day-high replaces it.
- R6: A write with `wr_region`=3 and data 1 while unlatched copies the live count into the snapshot and sets the latched state. Data 0 while latched clears the latched state. Any other write to region 3 does nothing. `rd_data` shows only the snapshot.
- R7: Day-high bit 6 is a halt bit. While it is set, ticks do not change the count.
- R8: A write with `wr_region`=0 while clock access is on loads the selected live field: seconds from data bits 5:0, minutes from 5:0, hours from 4:0, day low from 7:0, and day-high from bits 0, 6 and 7. With clock access off, the write is ignored. Writes to region 1 are always ignored.
- R9: When a latch write falls in the same cycle as a tick, the snapshot holds the count from before that tick. When a region-0 data write falls in the same cycle as a tick, the write takes effect and that tick is dropped.
- R10: After reset, the count is zero, the latched state is clear, `ram_bank` is 0 and clock access is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Processor write strobe |
| wr_region | input | 2 | Write region: 0 data, 1 unused, 2 select, 3 latch |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Selected snapshot register, or 0xFF with clock access off |
| ram_bank | output | 2 | Selected external RAM bank |
| clk_access | output | 1 | Clock register access on |

## Verification
A tick can arrive in the same cycle as a latch write, and also in the same cycle as a data write to a live field. The bench drives each pair in one cycle. For the latch case it checks that the snapshot shows the count from before the tick and that the following latch shows the advanced count. For the data-write case it checks that the written value stands and that the dropped tick left seconds unchanged. Every expected value comes from an arithmetic seconds/minutes/hours/days model kept in the bench, across a long tick sweep, several day rollovers and a day-count overflow.

// File: rtl/rtc_latch_regs.sv
module rtc_latch_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [1:0] wr_region,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [1:0] ram_bank,
  output logic       clk_access
);
  localparam logic [5:0] SEC_LAST = 6'd59;
  localparam logic [5:0] MIN_LAST = 6'd59;
  localparam logic [4:0] HR_LAST  = 5'd23;

  logic [5:0] sec_q, min_q;
  logic [4:0] hr_q;
  logic [8:0] day_q;
  logic       halt_q, ovf_q;
  logic       latched_q;
  logic [2:0] sel_q;
  logic [4:0][7:0] live_b, snap_q;

  wire data_wr  = wr_en && wr_region == 2'd0 && clk_access;
  wire sel_wr   = wr_en && wr_region == 2'd2;
  wire latch_wr = wr_en && wr_region == 2'd3;
  wire tick_go  = tick && !halt_q && !data_wr;

  assign live_b[0] = {2'b00, sec_q};
  assign live_b[1] = {2'b00, min_q};
  assign live_b[2] = {3'b000, hr_q};
  assign live_b[3] = day_q[7:0];
  assign live_b[4] = {ovf_q, halt_q, 5'b00000, day_q[8]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hr_q   <= '0;
      day_q  <= '0;
      halt_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (data_wr) begin
      case (sel_q)
        3'd0: sec_q <= wr_data[5:0];
        3'd1: min_q <= wr_data[5:0];
        3'd2: hr_q  <= wr_data[4:0];
        3'd3: day_q[7:0] <= wr_data;
        default: begin
          day_q[8] <= wr_data[0];
          halt_q   <= wr_data[6];
          ovf_q    <= wr_data[7];
        end
      endcase
    end else if (tick_go) begin
      if (sec_q == SEC_LAST) begin
        sec_q <= '0;
        if (min_q == MIN_LAST) begin
          min_q <= '0;
          if (hr_q == HR_LAST) begin
            hr_q  <= '0;
            day_q <= day_q + 9'd1;
            if (&day_q) ovf_q <= 1'b1;
          end else begin
            hr_q <= hr_q + 5'd1;
          end
        end else begin
          min_q <= min_q + 6'd1;
        end
      end else begin
        sec_q <= sec_q + 6'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latched_q <= 1'b0;
      snap_q    <= '0;
    end else if (latch_wr) begin
      if (!latched_q && wr_data == 8'd1) begin
        snap_q    <= live_b;
        latched_q <= 1'b1;
      end else if (latched_q && wr_data == 8'd0) begin
        latched_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_bank   <= '0;
      clk_access <= 1'b0;
      sel_q      <= '0;
    end else if (sel_wr) begin
      if (wr_data < 8'd4) begin
        ram_bank   <= wr_data[1:0];
        clk_access <= 1'b0;
      end else if (wr_data >= 8'h08 && wr_data <= 8'h0C) begin
        sel_q      <= wr_data[2:0] - 3'd0;
        clk_access <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = 8'hFF;
    if (clk_access) begin
      case (sel_q)
        3'd0:    rd_data = snap_q[0];
        3'd1:    rd_data = snap_q[1];
        3'd2:    rd_data = snap_q[2];
        3'd3:    rd_data = snap_q[3];
        default: rd_data = snap_q[4];
      endcase
    end
  end
endmodule

// File: rtl/rtc_latch_regs_chk.sv
module rtc_latch_regs_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [1:0]      wr_region,
  input logic [7:0]      wr_data,
  input logic [1:0]      ram_bank,
  input logic            clk_access,
  input logic [2:0]      sel,
  input logic            latched,
  input logic [4:0][7:0] snap,
  input logic            ovf,
  input logic            halt,
  input logic [5:0]      sec
);
  wire sel_wr   = wr_en && wr_region == 2'd2;
  wire latch_go = wr_en && wr_region == 2'd3 && wr_data == 8'd1 && !latched;
  wire data_wr  = wr_en && wr_region == 2'd0 && clk_access;

  AST_RAM_BANK_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && wr_data < 8'd4 |=> ram_bank == $past(wr_data[1:0]) && !clk_access); // R1
  AST_CLOCK_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && wr_data >= 8'h08 && wr_data <= 8'h0C |=> clk_access); // R2
  AST_SELECT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && ((wr_data >= 8'd4 && wr_data < 8'd8) || wr_data > 8'h0C)
    |=> $stable(ram_bank) && $stable(clk_access) && $stable(sel)); // R2
  AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_go |=> $stable(snap)); // R6
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(data_wr && sel == 3'd4) |=> ovf); // R5
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !data_wr |=> $stable(sec)); // R7
endmodule

bind rtc_latch_regs rtc_latch_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_region(wr_region),
  .wr_data(wr_data), .ram_bank(ram_bank), .clk_access(clk_access),
  .sel(sel_q), .latched(latched_q), .snap(snap_q), .ovf(ovf_q),
  .halt(halt_q), .sec(sec_q)
);

// File: tb/rtc_latch_regs_test.sv
`timescale 1ns/1ps
module rtc_latch_regs_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_region = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] ram_bank;
  logic clk_access;
  int checks = 0, failures = 0;
  int m_sec, m_min, m_hr, m_day, m_halt, m_ovf;
  logic [7:0] got;

  always #5 clk = ~clk;

  rtc_latch_regs uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_region(wr_region), .wr_data(wr_data), .rd_data(rd_data),
    .ram_bank(ram_bank), .clk_access(clk_access));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input int i);
    case (i)
      0: return 8'(m_sec);
      1: return 8'(m_min);
      2: return 8'(m_hr);
      3: return 8'(m_day % 256);
      default: return {1'(m_ovf), 1'(m_halt), 5'd0, 1'(m_day / 256)};
    endcase
  endfunction

  task automatic model_tick();
    if (m_halt == 0) begin
      m_sec++;
      if (m_sec == 60) begin m_sec = 0; m_min++; end
      if (m_min == 60) begin m_min = 0; m_hr++; end
      if (m_hr == 24) begin m_hr = 0; m_day++; end
      if (m_day == 512) begin m_day = 0; m_ovf = 1; end
    end
  endtask

  task automatic cpu_wr(input logic [1:0] rg, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_region = rg; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    model_tick();
  endtask

  task automatic latch_now();
    cpu_wr(2'd3, 8'd0);
    cpu_wr(2'd3, 8'd1);
  endtask

  task automatic read_reg(input int i, output logic [7:0] v);
    cpu_wr(2'd2, 8'(8 + i));
    v = rd_data;
  endtask

  task automatic set_reg(input int i, input logic [7:0] v);
    cpu_wr(2'd2, 8'(8 + i));
    cpu_wr(2'd0, v);
    case (i)
      0: m_sec = int'(v[5:0]);
      1: m_min = int'(v[5:0]);
      2: m_hr = int'(v[4:0]);
      3: m_day = (m_day / 256) * 256 + int'(v);
      default: begin
        m_day = (m_day % 256) + 256 * int'(v[0]);
        m_halt = int'(v[6]); m_ovf = int'(v[7]);
      end
    endcase
  endtask

  task automatic check_all(input string req);
    latch_now();
    for (int i = 0; i < 5; i++) begin
      read_reg(i, got);
      chk(req, got, exp_reg(i));
    end
  endtask

  task automatic set_time(input int d, input int h, input int m, input int s);
    set_reg(4, {7'd0, 1'(d / 256)});
    set_reg(3, 8'(d % 256));
    set_reg(2, 8'(h));
    set_reg(1, 8'(m));
    set_reg(0, 8'(s));
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] ref_v;
    logic [1:0] exp_bank;
    logic exp_acc;
    m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_halt = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 bank", {6'd0, ram_bank}, 8'd0);
    chk("R10 access", {7'd0, clk_access}, 8'd0);
    chk("R1 read off", rd_data, 8'hFF);
    check_all("R10 count");

    // R1 / R2 sweep of every select value up to 0x1F plus 0xFF
    exp_bank = 2'd0; exp_acc = 1'b1;
    for (int v = 0; v < 33; v++) begin
      logic [7:0] d;
      d = (v == 32) ? 8'hFF : 8'(v);
      cpu_wr(2'd2, d);
      if (d < 8'd4) begin exp_bank = d[1:0]; exp_acc = 1'b0; end
      else if (d >= 8'h08 && d <= 8'h0C) exp_acc = 1'b1;
      chk(d < 8'd4 ? "R1 bank" : "R2 select", {5'd0, exp_acc, exp_bank}, {5'd0, clk_access, ram_bank});
      if (!exp_acc) chk("R1 read off", rd_data, 8'hFF);
    end

    // R3 long tick sweep against the model
    set_time(0, 22, 58, 30);
    for (int n = 1; n <= 3700; n++) begin
      do_tick();
      if (n % 61 == 0) check_all("R3 sweep");
    end
    check_all("R3 sweep end");

    // R4 day rollovers: 0->1, 255->256, 300->301
    set_time(0, 23, 59, 59); do_tick(); check_all("R4 day 0->1");
    set_time(255, 23, 59, 59); do_tick(); check_all("R4 day 255->256");
    read_reg(4, got); chk("R4 bit8", got, 8'h01);
    set_time(300, 23, 59, 59); do_tick(); check_all("R4 day 300->301");

    // R5 overflow and stickiness
    set_time(511, 23, 59, 59); do_tick(); check_all("R5 overflow");
    read_reg(4, got); chk("R5 flag", got, 8'h80);
    set_reg(2, 8'd23); set_reg(1, 8'd59); set_reg(0, 8'd59);
    do_tick(); check_all("R5 sticky");
    read_reg(4, got); chk("R5 sticky flag", got, 8'h80);
    set_reg(4, 8'h00); check_all("R5 cleared");

    // R6 latch sequence
    set_time(5, 1, 2, 3);
    latch_now();
    read_reg(0, ref_v);
    do_tick(); do_tick();
    read_reg(0, got); chk("R6 frozen", got, ref_v);
    cpu_wr(2'd3, 8'd1); read_reg(0, got); chk("R6 relatch ignored", got, ref_v);
    cpu_wr(2'd3, 8'd2); cpu_wr(2'd3, 8'd1); read_reg(0, got); chk("R6 other value", got, ref_v);
    cpu_wr(2'd3, 8'd0); read_reg(0, got); chk("R6 unlatch keeps view", got, ref_v);
    cpu_wr(2'd3, 8'd7); cpu_wr(2'd3, 8'd1); read_reg(0, got); chk("R6 new snapshot", got, exp_reg(0));

    // R7 halt
    set_reg(4, 8'h40);
    for (int k = 0; k < 5; k++) do_tick();
    check_all("R7 halted");
    set_reg(4, 8'h00); do_tick(); check_all("R7 resumed");

    // R8 direct loads and ignored writes
    set_time(400, 13, 45, 17); check_all("R8 load");
    cpu_wr(2'd2, 8'd0); cpu_wr(2'd0, 8'd33); cpu_wr(2'd1, 8'd44);
    check_all("R8 ignored when off");
    cpu_wr(2'd2, 8'h08); cpu_wr(2'd1, 8'd44);
    check_all("R8 region 1 ignored");

    // R9 latch and tick in one cycle
    cpu_wr(2'd3, 8'd0);
    ref_v = exp_reg(0);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_region = 2'd3; wr_data = 8'd1;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    model_tick();
    read_reg(0, got); chk("R9 pre-tick snapshot", got, ref_v);
    check_all("R9 post-tick snapshot");

    // R9 data write and tick in one cycle: tick dropped
    cpu_wr(2'd2, 8'h08);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_region = 2'd0; wr_data = 8'd10;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    m_sec = 10;
    check_all("R9 write wins");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule